// File: doc/BRIEF.md
# Word-Wide Flash Command Controller with Boot-Block Lockout

This block is the control logic of a word-wide NOR-style flash memory built around a small array model. A host drives chip-enable, write-enable, output-enable, an address and a data word. Each clock cycle in which chip-enable and write-enable are both low counts as one bus write. Multi-write unlock sequences select read-array mode, a product-identification mode, word program, chip erase and a one-way boot-block lockout. Program and erase run for a fixed number of clock cycles with no host involvement. During that time, reads return polling and toggle status instead of array data.

A lockout flag guards the first 8K words. Once it is set, programs aimed at that region are refused and chip erase does nothing. An override input, standing in for a high-voltage level on the reset pin, suspends the guard while it is high. The flag survives reset, and it can be read back in identification mode. The active-low reset pin aborts any operation in progress and floats the data outputs. After release, the block stays deaf to the bus for a recovery period.

The array holds `DEPTH` words, indexed by the low address bits; higher address bits are not stored. Command decoding and the boot-region test use the full address.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low, `dq_oe` is 0, the command sequence and identification mode are cleared, and an operation in progress is abandoned: a word being programmed keeps its old value and an erase leaves the array unchanged.
- R2: After `rst_n` rises, for `RECOV_CYCLES` rising clock edges all writes are ignored and `dq_oe` stays 0, even with a read strobe.
- R3: In read-array mode, a read (`ce_n`=0, `oe_n`=0, `we_n`=1) sets `dq_oe`=1 and shows on `dq_out` the word stored at the index formed by the low address bits.
- R4: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 followed by one write of address/data start a program. After `PROG_CYCLES` cycles the addressed word equals the data, and reads return array data again.
- R5: While program or erase is busy, reads return bit 7 as the complement of bit 7 of the target data (0xFFFF for erase). Bit 6 inverts on every successive read, and all other bits are 0. Writes made while busy are ignored.
- R6: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10 start a chip erase. After `ERASE_CYCLES` cycles every word reads 0xFFFF and the block is in read-array mode.
- R7: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90 enter identification mode. In that mode, address 0 reads `MFR_CODE` (default 0x00DA), address 1 reads `DEV_CODE` (default 0x22BA), and address 2 reads the lockout flag on bit 0 (1 = locked) with the other bits 0. Every other address reads 0.
- R8: Identification mode is left either by the writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xF0 or by a single write of 0xF0 to any address.
- R9: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x40 set the lockout flag. The flag is not cleared by reset.
- R10: While the flag is set and `hv_override` is 0, a program to an address below 0x2000 is refused: no busy period follows and the word is unchanged. A program to a higher address proceeds, and chip erase does nothing.
- R11: While `hv_override` is 1, the lockout is inactive, so boot-region program and chip erase proceed. When `hv_override` returns to 0, the lockout applies again.
- R12: A write that does not match the next expected step of a sequence returns the block to read-array mode, leaving identification mode if it was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset pin |
| hv_override | input | 1 | High-voltage override flag; suspends lockout while 1 |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data; command byte in bits 7:0 |
| dq_out | output | DATA_W | Read data or status |
| dq_oe | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The assertions take for granted that each write strobe lasts exactly one clock and never overlaps a read. They also assume that `hv_override` is steady at the moment a program or erase is accepted, because the guard checks look at the cycle before busy rises. The bench tasks drive every access at the falling edge and hold it for a single cycle, with an idle cycle before each read so that every read counts as a new read for the toggle bit. Programs use addresses whose low bits do not collide, so that aliasing in the small array never hides a result.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 64,
  parameter int BOOT_WORDS   = 8192,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64,
  parameter int RECOV_CYCLES = 8,
  parameter logic [15:0] MFR_CODE = 16'h00DA,
  parameter logic [15:0] DEV_CODE = 16'h22BA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_override,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int REC_W = $clog2(RECOV_CYCLES + 1);
  localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_WORDS);
  localparam logic [ADDR_W-1:0] KEY_A    = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] KEY_B    = ADDR_W'(16'h2AAA);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_CMD, S_PROG, S_E1, S_E2, S_E3} seq_t;

  seq_t              seq;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              locked = 1'b0;
  logic              id_mode, busy, op_prog, tog, rd_q;
  logic [CNT_W-1:0]  cnt;
  logic [REC_W-1:0]  rec;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data;
  logic [DATA_W-1:0] rdata;

  wire       quiet   = (rec != '0);
  wire       wr      = !ce_n && !we_n && !quiet;
  wire       rd      = !ce_n && !oe_n && we_n;
  wire       shield  = locked && !hv_override;
  wire       at_a    = (addr == KEY_A);
  wire       at_b    = (addr == KEY_B);
  wire [7:0] cmd     = din[7:0];
  wire       in_boot = (addr < BOOT_LIM);
  wire       done    = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq      <= S_IDLE;
      id_mode  <= 1'b0;
      busy     <= 1'b0;
      op_prog  <= 1'b0;
      cnt      <= '0;
      rec      <= REC_W'(RECOV_CYCLES);
      tog      <= 1'b0;
      rd_q     <= 1'b0;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      rd_q <= rd;
      if (quiet) rec <= rec - 1'b1;
      if (busy) begin
        if (rd && !rd_q) tog <= ~tog;
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end else if (wr) begin
        seq <= S_IDLE;
        case (seq)
          S_IDLE: if (at_a && cmd == 8'hAA) seq <= S_U1;
                  else id_mode <= 1'b0;
          S_U1:   if (at_b && cmd == 8'h55) seq <= S_CMD;
                  else id_mode <= 1'b0;
          S_CMD: begin
            if (at_a && cmd == 8'hA0)      seq <= S_PROG;
            else if (at_a && cmd == 8'h80) seq <= S_E1;
            else if (at_a && cmd == 8'h90) id_mode <= 1'b1;
            else                           id_mode <= 1'b0;
          end
          S_PROG: if (!(shield && in_boot)) begin
            busy     <= 1'b1;
            op_prog  <= 1'b1;
            id_mode  <= 1'b0;
            tgt_addr <= addr;
            tgt_data <= din;
            cnt      <= CNT_W'(PROG_CYCLES - 1);
          end
          S_E1:   if (at_a && cmd == 8'hAA) seq <= S_E2;
                  else id_mode <= 1'b0;
          S_E2:   if (at_b && cmd == 8'h55) seq <= S_E3;
                  else id_mode <= 1'b0;
          S_E3: begin
            if (at_a && cmd == 8'h10) begin
              if (!shield) begin
                busy     <= 1'b1;
                op_prog  <= 1'b0;
                id_mode  <= 1'b0;
                tgt_addr <= '0;
                tgt_data <= '1;
                cnt      <= CNT_W'(ERASE_CYCLES - 1);
              end
            end else if (!(at_a && cmd == 8'h40)) id_mode <= 1'b0;
          end
          default: id_mode <= 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !busy && wr && seq == S_E3 && at_a && cmd == 8'h40) locked <= 1'b1;
    if (done) begin
      if (op_prog) mem[tgt_addr[IDX_W-1:0]] <= tgt_data;
      else for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end
  end

  always_comb begin
    rdata = '0;
    if (busy) begin
      rdata[7] = ~tgt_data[7];
      rdata[6] = tog;
    end else if (id_mode) begin
      if (addr == ADDR_W'(0))      rdata = DATA_W'(MFR_CODE);
      else if (addr == ADDR_W'(1)) rdata = DATA_W'(DEV_CODE);
      else if (addr == ADDR_W'(2)) rdata[0] = locked;
    end else begin
      rdata = mem[addr[IDX_W-1:0]];
    end
  end

  assign dq_out = rdata;
  assign dq_oe  = rd && rst_n && !quiet;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R9
  AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && op_prog && tgt_addr < BOOT_LIM) |-> $past(!locked || hv_override)); // R10
  AST_ERASE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !op_prog) |-> $past(!locked || hv_override)); // R11
  AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(seq) && $stable(id_mode)); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (seq == S_IDLE) && !busy && !id_mode); // R2
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hv_override = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0, din = '0;
  logic [15:0] dq_out;
  logic        dq_oe;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .hv_override(hv_override), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe));

  // {op, addr, data, req}: op 0 write, 1 read and compare, 2 wait data cycles
  localparam int NV = 36;
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 16'h5555, 16'h00AA, 4'd4}, {2'd0, 16'h2AAA, 16'h0055, 4'd4}, // R4
    {2'd0, 16'h5555, 16'h00A0, 4'd4}, {2'd0, 16'h2020, 16'h1234, 4'd4},
    {2'd2, 16'h0000, 16'd20,   4'd4}, {2'd1, 16'h2020, 16'h1234, 4'd4},
    {2'd0, 16'h5555, 16'h00AA, 4'd3}, {2'd0, 16'h2AAA, 16'h0055, 4'd3}, // R3
    {2'd0, 16'h5555, 16'h00A0, 4'd3}, {2'd0, 16'h2021, 16'hABCD, 4'd3},
    {2'd2, 16'h0000, 16'd20,   4'd3}, {2'd1, 16'h2021, 16'hABCD, 4'd3},
    {2'd1, 16'h2020, 16'h1234, 4'd3},
    {2'd0, 16'h5555, 16'h00AA, 4'd7}, {2'd0, 16'h2AAA, 16'h0055, 4'd7}, // R7
    {2'd0, 16'h5555, 16'h0090, 4'd7}, {2'd1, 16'h0000, 16'h00DA, 4'd7},
    {2'd1, 16'h0001, 16'h22BA, 4'd7}, {2'd1, 16'h0002, 16'h0000, 4'd7},
    {2'd1, 16'h2020, 16'h0000, 4'd7},
    {2'd0, 16'h3333, 16'h00F0, 4'd8}, {2'd1, 16'h2020, 16'h1234, 4'd8}, // R8
    {2'd0, 16'h5555, 16'h00AA, 4'd8}, {2'd0, 16'h2AAA, 16'h0055, 4'd8},
    {2'd0, 16'h5555, 16'h0090, 4'd8}, {2'd1, 16'h0001, 16'h22BA, 4'd8},
    {2'd0, 16'h5555, 16'h00AA, 4'd8}, {2'd0, 16'h2AAA, 16'h0055, 4'd8},
    {2'd0, 16'h5555, 16'h00F0, 4'd8}, {2'd1, 16'h2020, 16'h1234, 4'd8},
    {2'd0, 16'h5555, 16'h00AA, 4'd12}, {2'd0, 16'h2AAA, 16'h0055, 4'd12}, // R12
    {2'd0, 16'h5555, 16'h0090, 4'd12}, {2'd0, 16'h5555, 16'h00AA, 4'd12},
    {2'd0, 16'h1111, 16'h0055, 4'd12}, {2'd1, 16'h2020, 16'h1234, 4'd12}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; din = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v, output logic oe);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    #1 v = dq_out; oe = dq_oe;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] v; logic oe;
    rd(a, v, oe);
    chk({tag, " oe"}, {15'd0, oe}, 16'd1);
    chk(tag, v, exp);
  endtask

  task automatic unlock(input logic [7:0] c);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, {8'h00, c});
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d);
    unlock(8'hA0); wr(a, d);
  endtask

  task automatic long_cmd(input logic [7:0] c);
    unlock(8'h80); wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, {8'h00, c});
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1; checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2; logic oe;
    // R1: outputs float while reset is held, even with a read strobe
    @(negedge clk); ce_n = 0; oe_n = 0;
    #1 chk("R1 oe during reset", {15'd0, dq_oe}, 16'd0);
    @(negedge clk); ce_n = 1; oe_n = 1;
    rst_n = 1;
    settle(10);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][37:36])
        2'd0: wr(VEC[i][35:20], VEC[i][19:4]);
        2'd1: rd_chk($sformatf("R%0d table %0d", VEC[i][3:0], i), VEC[i][35:20], VEC[i][19:4]);
        default: settle(int'(VEC[i][19:4]));
      endcase
    end

    // R2: writes and reads during recovery are ignored
    pulse_reset();
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
    rd(16'h2020, v, oe);
    chk("R2 oe during recovery", {15'd0, oe}, 16'd0);
    wr(16'h2020, 16'hBEEF);
    rd_chk("R2 no program after recovery", 16'h2020, 16'h1234);

    // R5: status during program; writes while busy ignored
    prog(16'h2030, 16'h0070);
    rd(16'h2030, v, oe);
    chk("R5 poll bit7", {15'd0, v[7]}, 16'd1);
    chk("R5 other bits zero", v & 16'hFF3F, 16'h0000);
    unlock(8'h90);
    rd(16'h2030, v2, oe);
    chk("R5 toggle bit6", {15'd0, v2[6]}, {15'd0, ~v[6]});
    settle(20);
    rd_chk("R5 programmed, busy writes ignored", 16'h2030, 16'h0070);

    // R1: reset abandons a program in progress
    prog(16'h2040, 16'h1111);
    settle(20);
    prog(16'h2040, 16'h5A5A);
    settle(3);
    pulse_reset();
    settle(10);
    rd_chk("R1 abandoned program", 16'h2040, 16'h1111);

    // R6: chip erase with status
    prog(16'h0010, 16'h0A0A);
    settle(20);
    long_cmd(8'h10);
    rd(16'h2020, v, oe);
    chk("R6 erase poll bit7", {15'd0, v[7]}, 16'd0);
    settle(80);
    rd_chk("R6 erased high", 16'h2020, 16'hFFFF);
    rd_chk("R6 erased boot", 16'h0010, 16'hFFFF);

    // R9: lockout set, survives reset
    prog(16'h0010, 16'h0A0A);
    settle(20);
    prog(16'h2020, 16'h2222);
    settle(20);
    long_cmd(8'h40);
    unlock(8'h90);
    rd_chk("R9 lock status", 16'h0002, 16'h0001);
    pulse_reset();
    settle(10);
    unlock(8'h90);
    rd_chk("R9 lock after reset", 16'h0002, 16'h0001);
    wr(16'h0000, 16'h00F0);

    // R10: boot program refused, others proceed, erase disabled
    prog(16'h0010, 16'h5555);
    rd_chk("R10 boot refused no busy", 16'h0010, 16'h0A0A);
    settle(20);
    rd_chk("R10 boot unchanged", 16'h0010, 16'h0A0A);
    prog(16'h2020, 16'h7777);
    settle(20);
    rd_chk("R10 high program", 16'h2020, 16'h7777);
    long_cmd(8'h10);
    rd_chk("R10 erase refused no busy", 16'h2020, 16'h7777);
    settle(80);
    rd_chk("R10 erase did nothing", 16'h2020, 16'h7777);

    // R11: override suspends lockout
    hv_override = 1;
    prog(16'h0010, 16'h3C3C);
    settle(20);
    rd_chk("R11 boot program with override", 16'h0010, 16'h3C3C);
    hv_override = 0;
    prog(16'h0010, 16'h0001);
    settle(20);
    rd_chk("R11 lock back after override", 16'h0010, 16'h3C3C);
    hv_override = 1;
    long_cmd(8'h10);
    settle(80);
    hv_override = 0;
    rd_chk("R11 erase with override", 16'h0010, 16'hFFFF);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule